// File: doc/BRIEF.md
# Prescaled Wakeup Timer

This block is an always-running wakeup counter with a programmable prescaler. Once software turns on its enable, a small prescale counter runs every clock. Each time that counter wraps, the main count goes up by one. When the main count is at or above a software-chosen limit, the block sets a sticky interrupt bit. In the same cycle it sets a separate sticky cause flag, which drives a wakeup request to whatever logic wakes the system.

Software reaches the block through a plain register port: one write strobe, one read strobe, and one shared word address. Read data returns one cycle after the read strobe. The interrupt bit is cleared by writing 1 and can be forced by a test register. The cause flag is cleared only by writing 0 to it. The whole block runs on a single clock.

Top module: `wkt_top`

Register map (word address): 0 control, 1 limit, 2 count, 3 interrupt state, 4 interrupt force, 5 wakeup cause. Reading any other address returns 0, and so does reading the force register.

## Requirements
- R1: After reset, irq_wake and wake_req are 0, and reading control, limit, count, interrupt state, interrupt force and cause all return 0.
- R2: In the control register, bit 0 is the enable and bits 12:1 are the prescale value P. On a read, every other bit returns 0, whatever was written to it.
- R3: While enable is 1, the count goes up by exactly one every P+1 enabled clocks. With P = 0 it goes up every clock.
- R4: While enable is 0, the count keeps its value.
- R5: Limit (address 1) and count (address 2) are 32-bit read/write registers. If software writes the count in the same cycle as an increment, the written value is stored and the increment is dropped.
- R6: While enable is 1 and count >= limit, the interrupt state bit (bit 0 of address 3) is set at the next clock edge, and irq_wake follows that bit.
- R7: Writing 1 to bit 0 of address 3 clears the interrupt bit. If the expiry condition still holds in that cycle, the set wins and the bit stays 1.
- R8: Writing 1 to bit 0 of address 4 sets the interrupt bit. It does not change the cause flag. Writing 0 to bit 0 of address 4 has no effect.
- R9: The cause flag (bit 0 of address 5) is set together with the interrupt bit on expiry, and wake_req equals it. Writing 1 to it has no effect. Writing 0 to bit 0 clears it.
- R10: A read strobe in one cycle gives rd_valid = 1 in the next cycle, with the register value as it was at that edge. At all other times rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for the write or the read |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data, 0 when rd_valid is 0 |
| irq_wake | output | 1 | Wakeup interrupt (sticky state bit) |
| wake_req | output | 1 | Wakeup request (sticky cause flag) |

## Verification
The assertions assume that wr_en and rd_en are never both high in the same cycle. They also assume that addr is steady whenever a strobe is high. The bench drives each access from a task that raises exactly one strobe for one cycle, with addr and data held through that cycle. Each enabled run lasts a whole multiple of P+1 clocks, so the prescale counter is back at zero before the next run starts. This keeps every expected count exact without modelling the prescaler's internal phase.

// File: rtl/wkt_pkg.sv
// Package wkt_pkg
// Holds the shared widths, the register word addresses and the control
// field positions for the prescaled wakeup timer.
// Assumes: one word per register and a flat address space.
package wkt_pkg;
    parameter int CNT_W  = 32;
    parameter int PRE_W  = 12;
    parameter int ADDR_W = 3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PRE_LSB = 1;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_LIMIT  = 3'd1,
        A_COUNT  = 3'd2,
        A_IRQ    = 3'd3,
        A_FORCE  = 3'd4,
        A_CAUSE  = 3'd5
    } wkt_addr_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             en;
    } wkt_ctrl_t;
endpackage

// File: rtl/wkt_flag.sv
// Module wkt_flag
// A sticky status bit. The set input has priority over the clear input.
// Assumes: set and clr are single-cycle strobes in the clk domain.
module wkt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Keep the bit; the set input wins over the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/wkt_prescale.sv
// Module wkt_prescale
// Divides the clock by (pre_val + 1) while enabled and gives a one-cycle
// tick on the cycle in which the prescale counter wraps.
// Assumes: pre_val may change at any time. The counter holds while the
// block is disabled.
module wkt_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic             wrap;

    // Wrap when the counter matches the programmed prescale value.
    always_comb begin
        wrap = (pre_cnt == pre_val);
        tick = en && wrap;
    end

    // Step the prescale counter while enabled; restart at zero on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (en) pre_cnt <= wrap ? '0 : pre_cnt + 1'b1;
    end
endmodule

// File: rtl/wkt_counter.sv
// Module wkt_counter
// The main wakeup count and the expiry compare against the limit.
// Assumes: a software load (ld) has priority over a tick in the same cycle.
module wkt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    // Expiry: while enabled, the count is at or above the limit.
    always_comb expired = en && (count >= limit);

    // Load from software first; otherwise add one on each prescale tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (ld)      count <= ld_val;
        else if (tick)    count <= count + 1'b1;
    end
endmodule

// File: rtl/wkt_regs.sv
// Module wkt_regs
// Register front end: holds the control and limit registers, decodes
// writes into strobes for the other parts, and returns registered reads.
// Assumes: wr_en and rd_en are not high together; addr is a word address.
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count,
    input  logic              irq_q,
    input  logic              cause_q,
    output logic              ctrl_en,
    output logic [PRE_W-1:0]  pre_val,
    output logic [CNT_W-1:0]  limit,
    output logic              cnt_ld,
    output logic              irq_clr,
    output logic              irq_force,
    output logic              cause_clr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int CTRL_W = PRE_W + 1;

    wkt_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] rd_mux;
    logic            hit_ctrl, hit_limit, hit_count, hit_irq, hit_force, hit_cause;

    // Decode the word address once for both directions.
    always_comb begin
        hit_ctrl  = (addr == ADDR_W'(A_CTRL));
        hit_limit = (addr == ADDR_W'(A_LIMIT));
        hit_count = (addr == ADDR_W'(A_COUNT));
        hit_irq   = (addr == ADDR_W'(A_IRQ));
        hit_force = (addr == ADDR_W'(A_FORCE));
        hit_cause = (addr == ADDR_W'(A_CAUSE));
    end

    // Turn writes into single-cycle strobes for the count and the flags.
    always_comb begin
        cnt_ld    = wr_en && hit_count;
        irq_clr   = wr_en && hit_irq   &&  wr_data[0];
        irq_force = wr_en && hit_force &&  wr_data[0];
        cause_clr = wr_en && hit_cause && !wr_data[0];
    end

    // Store the control and limit registers on their writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            limit  <= '0;
        end else if (wr_en) begin
            if (hit_ctrl)  ctrl_q <= wkt_ctrl_t'(wr_data[CTRL_PRE_LSB+PRE_W-1:CTRL_EN_BIT]);
            if (hit_limit) limit  <= wr_data;
        end
    end

    // Pass the control fields on to the datapath.
    always_comb begin
        ctrl_en = ctrl_q.en;
        pre_val = ctrl_q.pre;
    end

    // Pick the addressed register; unmapped and write-only addresses give 0.
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)  rd_mux = CNT_W'({ctrl_q.pre, ctrl_q.en});
        if (hit_limit) rd_mux = limit;
        if (hit_count) rd_mux = count;
        if (hit_irq)   rd_mux = CNT_W'(irq_q);
        if (hit_cause) rd_mux = CNT_W'(cause_q);
    end

    // Register the read response so that it is valid the cycle after rd_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end

    if (CTRL_W > CNT_W) begin : g_bad_width
        initial $error("control register wider than data path");
    end
endmodule

// File: rtl/wkt_top.sv
// Module wkt_top
// Prescaled wakeup timer: register front end, prescaler, main count,
// sticky interrupt bit and sticky wakeup-cause flag.
// Assumes: a single clock domain and a synchronous active-low reset.
module wkt_top
    import wkt_pkg::*;
#(
    parameter int CNT_W  = wkt_pkg::CNT_W,
    parameter int PRE_W  = wkt_pkg::PRE_W,
    parameter int ADDR_W = wkt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_wake,
    output logic              wake_req
);
    logic             ctrl_en;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             cnt_ld, irq_clr, irq_force, cause_clr;
    logic             tick, expired;
    logic             irq_q, cause_q;
    logic             irq_set;

    wkt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .count(count), .irq_q(irq_q), .cause_q(cause_q),
        .ctrl_en(ctrl_en), .pre_val(pre_val), .limit(limit), .cnt_ld(cnt_ld),
        .irq_clr(irq_clr), .irq_force(irq_force), .cause_clr(cause_clr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    wkt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .pre_val(pre_val), .tick(tick)
    );

    wkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick), .ld(cnt_ld),
        .ld_val(wr_data), .limit(limit), .count(count), .expired(expired)
    );

    // The interrupt bit is set by an expiry or by a forced test write.
    always_comb irq_set = expired || irq_force;

    wkt_flag u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .q(irq_q)
    );

    wkt_flag u_cause (
        .clk(clk), .rst_n(rst_n), .set(expired), .clr(cause_clr), .q(cause_q)
    );

    // Drive the outputs straight from the two sticky bits.
    always_comb begin
        irq_wake = irq_q;
        wake_req = cause_q;
    end
endmodule

// File: rtl/wkt_checker.sv
// Module wkt_checker
// Temporal checks on the wakeup timer, attached to wkt_top by bind.
// Assumes: the bench never raises wr_en and rd_en in the same cycle.
module wkt_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              rd_valid,
    input logic              irq_wake,
    input logic              wake_req,
    input logic              ctrl_en,
    input logic              tick,
    input logic [CNT_W-1:0]  count
);
    logic cnt_write;
    logic cause_zero_write;
    always_comb begin
        cnt_write        = wr_en && (addr == ADDR_W'(2));
        cause_zero_write = wr_en && (addr == ADDR_W'(5)) && !wr_data[0];
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !cnt_write) |=> (count == $past(count)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_write) |=> (count == $past(count) + 1'b1));

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> (count == $past(wr_data)));

    assert_cause_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> irq_wake);

    assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !cause_zero_write) |=> wake_req);

    assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

bind wkt_top wkt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wkt_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .irq_wake(irq_wake),
    .wake_req(wake_req), .ctrl_en(ctrl_en), .tick(tick), .count(count)
);

// File: tb/wkt_top_bench.sv
module wkt_top_bench;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;
    localparam int WATCHDOG_CYCLES = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              rd_en = 1'b0;
    logic              rd_valid;
    logic [CNT_W-1:0]  rd_data;
    logic              irq_wake;
    logic              wake_req;

    int total = 0;
    int bad   = 0;
    logic [CNT_W-1:0] exp_q[$];
    string            tag_q[$];
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    wkt_top u_wkt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_wake(irq_wake), .wake_req(wake_req)
    );

    // Monitor: pop an expected read value for each valid response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10: unexpected read data actual=%h expected=none", rd_data);
            end else begin
                logic [CNT_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: read actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string t, input logic act, input logic e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", t, act, e);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk("R1 irq_wake", irq_wake, 1'b0);
        chk("R1 wake_req", wake_req, 1'b0);
        rd(3'd0, 32'h0, "R1 ctrl");
        rd(3'd1, 32'h0, "R1 limit");
        rd(3'd2, 32'h0, "R1 count");
        rd(3'd3, 32'h0, "R1 irq state");
        rd(3'd4, 32'h0, "R1 force");
        rd(3'd5, 32'h0, "R1 cause");

        // R5: plain read/write of limit and count
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, 32'h1234_5678, "R5 limit");
        wr(3'd2, 32'hCAFE_0001);
        rd(3'd2, 32'hCAFE_0001, "R5 count");

        // R2: field layout, upper bits dropped
        wr(3'd0, 32'hFFFF_E000 | (32'hABC << 1));
        rd(3'd0, 32'h0000_1578, "R2 ctrl fields");

        // R3/R4: prescaled counting, then hold
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0);
        wr(3'd0, (32'd3 << 1) | 32'd1);
        idle(19);
        wr(3'd0, (32'd3 << 1));
        rd(3'd2, 32'd5, "R3 prescale 3 gives 5 steps in 20 clocks");
        idle(20);
        rd(3'd2, 32'd5, "R4 count held while disabled");
        wr(3'd0, 32'd1);
        idle(9);
        wr(3'd0, 32'd0);
        rd(3'd2, 32'd15, "R3 prescale 0 steps every clock");

        // R5: software write beats a same-cycle increment
        wr(3'd0, 32'd1);
        wr(3'd2, 32'd100);
        rd(3'd2, 32'd100, "R5 load wins over tick");
        wr(3'd0, 32'd0);
        rd(3'd2, 32'd102, "R5 counting resumes after load");

        // R6: expiry timing
        wr(3'd2, 32'd3);
        wr(3'd1, 32'd5);
        wr(3'd0, 32'd1);
        chk("R6 not expired at count 3", irq_wake, 1'b0);
        idle(1);
        chk("R6 not expired at count 4", irq_wake, 1'b0);
        idle(1);
        chk("R6 set lands one edge after reach", irq_wake, 1'b0);
        idle(1);
        chk("R6 irq after reach", irq_wake, 1'b1);
        chk("R9 wake_req after reach", wake_req, 1'b1);

        // R7: clear loses to a live condition, works once disabled
        wr(3'd3, 32'd1);
        chk("R7 set wins over clear", irq_wake, 1'b1);
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd1);
        chk("R7 cleared by write 1", irq_wake, 1'b0);
        rd(3'd3, 32'd0, "R7 state reads 0");

        // R9: cause ignores 1, clears on 0
        chk("R9 cause sticky after irq clear", wake_req, 1'b1);
        wr(3'd5, 32'd1);
        chk("R9 writing 1 keeps cause", wake_req, 1'b1);
        rd(3'd5, 32'd1, "R9 cause reads 1");
        wr(3'd5, 32'd0);
        chk("R9 writing 0 clears cause", wake_req, 1'b0);

        // R8: forced interrupt
        wr(3'd4, 32'd2);
        chk("R8 force bit0 clear has no effect", irq_wake, 1'b0);
        wr(3'd4, 32'd1);
        chk("R8 force sets irq", irq_wake, 1'b1);
        chk("R8 force leaves cause", wake_req, 1'b0);
        rd(3'd3, 32'd1, "R8 state reads 1");
        wr(3'd3, 32'd1);
        chk("R8 forced irq clears", irq_wake, 1'b0);

        // R10: unmapped address
        rd(3'd7, 32'd0, "R10 unmapped reads 0");

        idle(3);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R10: missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule